// File: doc/BRIEF.md
# Dual-Port Frame Transfer Controller

This block moves a frame of 32-bit words between a processor and an external bus. A 256-word dual-port buffer stages the frame. The processor owns one port of the buffer and can read or write any word at any time. The controller owns the other port. To start a transfer, the processor writes a single operation word. That word holds a direction bit and a trigger value equal to the word count minus one. The controller then walks the buffer from address 0 upward and moves exactly trigger+1 words. When the last word has moved, it raises a one-cycle completion interrupt.

In the outbound direction, the controller reads buffered words and presents them on a valid/ready output stream. In the inbound direction, it accepts words from a valid/ready input stream and writes them into the buffer, where the processor later picks them up. While a transfer is running, a busy flag is visible in the operation readback, and further operation writes are ignored.

Top module: `frame_xfer_ctrl`

## Requirements
- R1: After reset, `op_rdata` is 0 (busy 0, direction 0, trigger 0), `done_irq` is 0, `ext_out_valid` is 0 and `ext_in_ready` is 0.
- R2: An `op_wr` while idle latches `op_wdata[7:0]` as the trigger and `op_wdata[8]` as the direction. Busy is set from the next cycle. `op_rdata` reads back {busy at bit 9, direction at bit 8, trigger at bits 7:0}.
- R3: An `op_wr` while busy is ignored: direction and trigger in `op_rdata` stay unchanged and the running transfer is unaffected.
- R4: With direction 1 (buffer to bus), the words at buffer addresses 0, 1, 2, ... appear on `ext_out_data` in ascending order. Each is held with `ext_out_valid` until a cycle in which `ext_out_ready` is 1. `ext_out_valid` is never 1 otherwise.
- R5: With direction 0 (bus to buffer), each word presented while `ext_in_valid` and `ext_in_ready` are both 1 is written to buffer addresses 0, 1, 2, ... in order. `ext_in_ready` is 1 only during an inbound transfer.
- R6: A transfer moves exactly trigger+1 words. No word is offered or accepted beyond that, and buffer words past the last one stay untouched.
- R7: `done_irq` is high for exactly one cycle, the cycle after the last word moves. Busy is already clear in that cycle.
- R8: A trigger of 0 moves a single word, and a trigger of 255 moves all 256 buffer words, in both directions.
- R9: The processor port writes a buffer word when `cpu_buf_we` is 1. `cpu_buf_rdata` shows the word at `cpu_buf_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_wr | input | 1 | Operation register write strobe |
| op_wdata | input | 9 | Bit 8 direction, bits 7:0 trigger (word count minus one) |
| op_rdata | output | 10 | Bit 9 busy, bit 8 direction, bits 7:0 trigger |
| cpu_buf_we | input | 1 | Processor buffer write enable |
| cpu_buf_addr | input | 8 | Processor buffer address |
| cpu_buf_wdata | input | 32 | Processor buffer write data |
| cpu_buf_rdata | output | 32 | Processor buffer read data, one cycle latency |
| ext_out_valid | output | 1 | Outbound word valid |
| ext_out_ready | input | 1 | External bus accepts outbound word |
| ext_out_data | output | 32 | Outbound word |
| ext_in_valid | input | 1 | Inbound word valid |
| ext_in_ready | output | 1 | Controller accepts inbound word |
| ext_in_data | input | 32 | Inbound word |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Outbound transfers run both with a continuously ready receiver and with a receiver that withholds ready on a fixed pattern. Together these separate correct holding of a stalled word from skipping or repeating words. Inbound transfers use a sender that drops valid on some cycles. A sentinel word just past the frame, plus extra valid cycles after the end, expose an off-by-one length. Frames of 1, 5, 8, 12 and 256 words cover both counter limits. An operation write issued during a stalled transfer shows whether the busy guard protects the latched fields.

// File: rtl/frame_xfer_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the frame transfer controller.
// Assumes: nothing beyond SystemVerilog 2017.
package frame_xfer_pkg;

    // Sequencer states: idle, fetch a buffer word, present it, receive a word.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_SHOW  = 2'd2,
        SEQ_RECV  = 2'd3
    } seq_state_t;

    // Direction bit value meaning buffer contents go out to the external bus.
    localparam logic DIR_TO_BUS = 1'b1;

endpackage

// File: rtl/frame_xfer_dpram.sv
`timescale 1ns/1ps
// Module: two-port word buffer. Port A belongs to the processor
// (read every cycle, optional write). Port B belongs to the sequencer
// (read on request, optional write). Reads are registered: one cycle latency.
// Assumes: if both ports write the same address in one cycle, port B wins.
module frame_xfer_dpram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_re,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage writes from both ports; port B is applied last so it takes priority.
    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
    end

    // Registered read ports; port B output holds between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            a_rdata <= mem[a_addr];
            if (b_re) begin
                b_rdata <= mem[b_addr];
            end
        end
    end

endmodule

// File: rtl/frame_xfer_opreg.sv
`timescale 1ns/1ps
// Module: operation register. Holds the direction bit and the trigger
// (word count minus one). Accepts a write only when no transfer is running,
// and that accepted write is the start strobe for the sequencer.
// Assumes: busy comes from the sequencer's registered state.
module frame_xfer_opreg #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_wr,
    input  logic [ADDR_W:0]   op_wdata,
    input  logic              busy,
    output logic              start,
    output logic              dir_q,
    output logic [ADDR_W-1:0] trig_q
);
    // Accept a write only while idle.
    always_comb begin
        start = op_wr && !busy;
    end

    // Latch both fields together on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            trig_q <= '0;
        end else if (start) begin
            dir_q  <= op_wdata[ADDR_W];
            trig_q <= op_wdata[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/frame_xfer_seq.sv
`timescale 1ns/1ps
// Module: transfer sequencer. Owns buffer port B, the address counter
// (counts up from 0) and the words-left counter (counts down from the trigger).
// Outbound: fetch a word, then present it until the bus takes it (two cycles
// minimum per word). Inbound: accept a word per valid cycle and write it.
// Ends after trigger+1 words with a one-cycle completion pulse.
// Assumes: start only arrives while idle.
module frame_xfer_seq
    import frame_xfer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_in,
    input  logic [ADDR_W-1:0] trig_in,
    input  logic              ext_out_ready,
    input  logic              ext_in_valid,
    input  logic [DATA_W-1:0] ext_in_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done_irq,
    output logic              ext_out_valid,
    output logic [DATA_W-1:0] ext_out_data,
    output logic              ext_in_ready,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] word_addr,
    output logic [ADDR_W-1:0] words_left
);
    seq_state_t state;
    logic       word_moved;
    logic       last_word;

    // Decode per-state outputs and the word-moved event.
    always_comb begin
        busy          = (state != SEQ_IDLE);
        mem_re        = (state == SEQ_FETCH);
        ext_out_valid = (state == SEQ_SHOW);
        ext_in_ready  = (state == SEQ_RECV);
        ext_out_data  = mem_rdata;
        mem_addr      = word_addr;
        mem_wdata     = ext_in_data;
        mem_we        = ext_in_ready && ext_in_valid;
        word_moved    = (ext_out_valid && ext_out_ready) || mem_we;
        last_word     = (words_left == '0);
    end

    // State, counters and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            word_addr  <= '0;
            words_left <= '0;
            done_irq   <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        word_addr  <= '0;
                        words_left <= trig_in;
                        state      <= (dir_in == DIR_TO_BUS) ? SEQ_FETCH : SEQ_RECV;
                    end
                end
                SEQ_FETCH: begin
                    state <= SEQ_SHOW;
                end
                SEQ_SHOW, SEQ_RECV: begin
                    if (word_moved) begin
                        if (last_word) begin
                            state    <= SEQ_IDLE;
                            done_irq <= 1'b1;
                        end else begin
                            word_addr  <= word_addr + 1'b1;
                            words_left <= words_left - 1'b1;
                            if (state == SEQ_SHOW) begin
                                state <= SEQ_FETCH;
                            end
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/frame_xfer_ctrl.sv
`timescale 1ns/1ps
// Module: top of the frame transfer controller. Joins the operation
// register, the sequencer and the two-port buffer.
// Assumes: a single clock domain; the external bus side has already won
// arbitration and inserts its own waits through the valid/ready pairs.
module frame_xfer_ctrl #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_wr,
    input  logic [ADDR_W:0]   op_wdata,
    output logic [ADDR_W+1:0] op_rdata,
    input  logic              cpu_buf_we,
    input  logic [ADDR_W-1:0] cpu_buf_addr,
    input  logic [DATA_W-1:0] cpu_buf_wdata,
    output logic [DATA_W-1:0] cpu_buf_rdata,
    output logic              ext_out_valid,
    input  logic              ext_out_ready,
    output logic [DATA_W-1:0] ext_out_data,
    input  logic              ext_in_valid,
    output logic              ext_in_ready,
    input  logic [DATA_W-1:0] ext_in_data,
    output logic              done_irq
);
    logic              busy;
    logic              start;
    logic              dir_q;
    logic [ADDR_W-1:0] trig_q;
    logic              mem_re;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] words_left;

    frame_xfer_opreg #(.ADDR_W(ADDR_W)) u_opreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_wr    (op_wr),
        .op_wdata (op_wdata),
        .busy     (busy),
        .start    (start),
        .dir_q    (dir_q),
        .trig_q   (trig_q)
    );

    frame_xfer_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .dir_in        (op_wdata[ADDR_W]),
        .trig_in       (op_wdata[ADDR_W-1:0]),
        .ext_out_ready (ext_out_ready),
        .ext_in_valid  (ext_in_valid),
        .ext_in_data   (ext_in_data),
        .mem_rdata     (mem_rdata),
        .busy          (busy),
        .done_irq      (done_irq),
        .ext_out_valid (ext_out_valid),
        .ext_out_data  (ext_out_data),
        .ext_in_ready  (ext_in_ready),
        .mem_re        (mem_re),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .word_addr     (word_addr),
        .words_left    (words_left)
    );

    frame_xfer_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (cpu_buf_we),
        .a_addr  (cpu_buf_addr),
        .a_wdata (cpu_buf_wdata),
        .a_rdata (cpu_buf_rdata),
        .b_re    (mem_re),
        .b_we    (mem_we),
        .b_addr  (mem_addr),
        .b_wdata (mem_wdata),
        .b_rdata (mem_rdata)
    );

    // Readback of the operation register with the busy flag on top.
    always_comb begin
        op_rdata = {busy, dir_q, trig_q};
    end

endmodule

// File: rtl/frame_xfer_ctrl_chk.sv
`timescale 1ns/1ps
// Module: property checker for frame_xfer_ctrl, attached by bind.
// Assumes: word_addr and words_left are the sequencer's two counters.
module frame_xfer_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_wr,
    input logic [ADDR_W+1:0] op_rdata,
    input logic              ext_out_valid,
    input logic              ext_out_ready,
    input logic [DATA_W-1:0] ext_out_data,
    input logic              ext_in_ready,
    input logic              done_irq,
    input logic [ADDR_W-1:0] word_addr,
    input logic [ADDR_W-1:0] words_left
);
    logic busy;
    assign busy = op_rdata[ADDR_W+1];

    assert_start_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_wr));

    assert_fields_hold_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_rdata[ADDR_W:0]));

    assert_out_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_out_valid && !ext_out_ready) |=> (ext_out_valid && $stable(ext_out_data)));

    assert_out_only_outbound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_out_valid |-> (busy && op_rdata[ADDR_W]));

    assert_in_only_inbound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_in_ready |-> (busy && !op_rdata[ADDR_W]));

    assert_counters_sum_to_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (({1'b0, word_addr} + {1'b0, words_left}) == {1'b0, op_rdata[ADDR_W-1:0]}));

    assert_irq_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_irq_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!busy && $past(busy)));

endmodule

bind frame_xfer_ctrl frame_xfer_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_wr         (op_wr),
    .op_rdata      (op_rdata),
    .ext_out_valid (ext_out_valid),
    .ext_out_ready (ext_out_ready),
    .ext_out_data  (ext_out_data),
    .ext_in_ready  (ext_in_ready),
    .done_irq      (done_irq),
    .word_addr     (word_addr),
    .words_left    (words_left)
);

// File: tb/frame_xfer_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module frame_xfer_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_wr = 1'b0;
    logic [8:0]  op_wdata = '0;
    logic [9:0]  op_rdata;
    logic        cpu_buf_we = 1'b0;
    logic [7:0]  cpu_buf_addr = '0;
    logic [31:0] cpu_buf_wdata = '0;
    logic [31:0] cpu_buf_rdata;
    logic        ext_out_valid;
    logic        ext_out_ready = 1'b0;
    logic [31:0] ext_out_data;
    logic        ext_in_valid = 1'b0;
    logic        ext_in_ready;
    logic [31:0] ext_in_data = '0;
    logic        done_irq;

    int tests = 0;
    int fails = 0;
    int irq_count = 0;

    always #2.5 clk = ~clk;

    frame_xfer_ctrl u_frame_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_wdata(op_wdata), .op_rdata(op_rdata),
        .cpu_buf_we(cpu_buf_we), .cpu_buf_addr(cpu_buf_addr), .cpu_buf_wdata(cpu_buf_wdata),
        .cpu_buf_rdata(cpu_buf_rdata), .ext_out_valid(ext_out_valid), .ext_out_ready(ext_out_ready),
        .ext_out_data(ext_out_data), .ext_in_valid(ext_in_valid), .ext_in_ready(ext_in_ready),
        .ext_in_data(ext_in_data), .done_irq(done_irq)
    );

    // Count completion pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (done_irq) irq_count <= irq_count + 1;
    end

    function automatic logic [31:0] pat(input int seed, input int i);
        return (32'(seed) << 24) ^ (32'(i) * 32'h0001_0101) ^ 32'h1357_9BDF;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic buf_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cpu_buf_we = 1'b1; cpu_buf_addr = 8'(a); cpu_buf_wdata = d;
        @(negedge clk);
        cpu_buf_we = 1'b0;
    endtask

    task automatic buf_read(input int a, output logic [31:0] d);
        @(negedge clk);
        cpu_buf_addr = 8'(a);
        @(negedge clk);
        d = cpu_buf_rdata;
    endtask

    task automatic op_write(input logic dir, input logic [7:0] trig);
        @(negedge clk);
        op_wr = 1'b1; op_wdata = {dir, trig};
        @(negedge clk);
        op_wr = 1'b0;
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) buf_write(i, pat(seed, i));
    endtask

    // R1: idle state after reset.
    task automatic t_reset();
        @(negedge clk);
        check(op_rdata == 10'd0, "R1", "op_rdata after reset", 32'(op_rdata), 0);
        check({done_irq, ext_out_valid, ext_in_ready} == 3'b000, "R1", "irq/valid/ready after reset",
              32'({done_irq, ext_out_valid, ext_in_ready}), 0);
    endtask

    // R9: processor port write then read back.
    task automatic t_cpu_port();
        logic [31:0] d;
        buf_write(17, 32'hCAFE_0011);
        buf_write(200, 32'h0BAD_F00D);
        buf_read(17, d);
        check(d == 32'hCAFE_0011, "R9", "cpu readback addr 17", d, 32'hCAFE_0011);
        buf_read(200, d);
        check(d == 32'h0BAD_F00D, "R9", "cpu readback addr 200", d, 32'h0BAD_F00D);
    endtask

    // R4 R6 R7: buffer to bus, optional throttled receiver.
    task automatic t_outbound(input int n, input bit throttle, input int seed, input string req);
        int k = 0; int cyc = 0; int extra = 0; int bad = 0; int irq0;
        logic [31:0] first_bad = '0;
        fill(n, seed);
        irq0 = irq_count;
        op_write(1'b1, 8'(n - 1));
        check(op_rdata == {1'b1, 1'b1, 8'(n - 1)}, "R2", "readback after start",
              32'(op_rdata), 32'({1'b1, 1'b1, 8'(n - 1)}));
        while (k < n && cyc < 5000) begin
            ext_out_ready = throttle ? ((cyc % 3) != 1) : 1'b1;
            if (ext_out_valid && ext_out_ready) begin
                if (ext_out_data !== pat(seed, k)) begin
                    if (bad == 0) first_bad = ext_out_data;
                    bad++;
                end
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        ext_out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (ext_out_valid) extra++;
            @(negedge clk);
        end
        ext_out_ready = 1'b0;
        check(bad == 0, "R4", $sformatf("%s outbound word order", req), first_bad, pat(seed, 0));
        check(k == n && extra == 0, "R6", $sformatf("%s outbound words moved", req),
              32'(k + extra), 32'(n));
        check(irq_count - irq0 == 1 && !op_rdata[9], "R7", $sformatf("%s outbound irq pulses", req),
              32'(irq_count - irq0), 1);
    endtask

    // R5 R6 R7: bus to buffer with valid gaps and a sentinel past the frame.
    task automatic t_inbound(input int n, input bit gappy, input int seed, input string req);
        int k = 0; int cyc = 0; int extra = 0; int bad = 0; int irq0;
        logic [31:0] d; logic [31:0] first_bad = '0;
        if (n < 256) buf_write(n, 32'hDEAD_0000);
        irq0 = irq_count;
        op_write(1'b0, 8'(n - 1));
        while (k < n && cyc < 5000) begin
            ext_in_valid = gappy ? ((cyc % 4) != 2) : 1'b1;
            ext_in_data  = pat(seed, k);
            if (ext_in_valid && ext_in_ready) k++;
            @(negedge clk);
            cyc++;
        end
        ext_in_valid = 1'b1;
        ext_in_data  = 32'hFFFF_FFFF;
        for (int i = 0; i < 4; i++) begin
            if (ext_in_ready) extra++;
            @(negedge clk);
        end
        ext_in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            buf_read(i, d);
            if (d !== pat(seed, i)) begin
                if (bad == 0) first_bad = d;
                bad++;
            end
        end
        check(bad == 0, "R5", $sformatf("%s inbound buffer contents", req), first_bad, pat(seed, 0));
        check(k == n && extra == 0, "R6", $sformatf("%s inbound words accepted", req),
              32'(k + extra), 32'(n));
        if (n < 256) begin
            buf_read(n, d);
            check(d == 32'hDEAD_0000, "R6", "word past frame untouched", d, 32'hDEAD_0000);
        end
        check(irq_count - irq0 == 1 && !op_rdata[9], "R7", $sformatf("%s inbound irq pulses", req),
              32'(irq_count - irq0), 1);
    endtask

    // R3: a write while busy leaves fields and transfer unchanged.
    task automatic t_busy_ignore();
        int k = 0; int cyc = 0; int bad = 0; int irq0; int inrdy = 0;
        fill(4, 9);
        irq0 = irq_count;
        ext_out_ready = 1'b0;
        op_write(1'b1, 8'd3);
        repeat (3) @(negedge clk);
        op_write(1'b0, 8'h55);
        check(op_rdata == {1'b1, 1'b1, 8'd3}, "R3", "fields after busy write",
              32'(op_rdata), 32'({1'b1, 1'b1, 8'd3}));
        while (k < 4 && cyc < 1000) begin
            ext_out_ready = 1'b1;
            if (ext_in_ready) inrdy++;
            if (ext_out_valid) begin
                if (ext_out_data !== pat(9, k)) bad++;
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        ext_out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(k == 4 && bad == 0 && inrdy == 0, "R3", "transfer unaffected by busy write",
              32'(k), 4);
        check(irq_count - irq0 == 1 && op_rdata == {1'b0, 1'b1, 8'd3}, "R3", "one irq, fields kept",
              32'(op_rdata), 32'({1'b0, 1'b1, 8'd3}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cpu_port();
        t_outbound(8, 1'b1, 1, "R4 throttled");
        t_outbound(5, 1'b0, 2, "R4 continuous");
        t_inbound(12, 1'b1, 3, "R5 gappy");
        t_busy_ignore();
        t_outbound(1, 1'b1, 4, "R8 single");
        t_inbound(1, 1'b0, 5, "R8 single");
        t_outbound(256, 1'b1, 6, "R8 full");
        t_inbound(256, 1'b1, 7, "R8 full");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule